// File: doc/BRIEF.md
# Change-of-state input interrupt controller

This block samples 32 digital inputs and lets a host read them over a simple 32-bit register bus. The lower 16 inputs can also raise an interrupt when their state changes in a chosen way. Each of these channels has two selection bits. One sits in the "high" select register and one in the "low" select register. The meaning of the two bits depends on the combining mode in the control register.

In edge-combining mode, the interrupt fires as soon as any selected channel shows a selected edge. The high select picks rising edges and the low select picks falling edges. In level-combining mode, the interrupt fires once every selected channel sits at its selected level at the same moment. The high select means the channel must be high and the low select means it must be low. After a level-mode firing, the combined condition must first drop before it can fire again.

A sticky status register records which channels met their condition. The bits accumulate until the host reads the register, and the read clears it. The interrupt line is high while status is pending and the enable bit is set. All inputs pass through a two-flop synchroniser before use.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, and the status, both select registers and control all read as zero.
- R2: A read at word offset 0x00 returns all 32 synchronised inputs, with input n in bit n.
- R3: The select registers at 0x04 (high/rising) and 0x08 (low/falling) store bits 15:0 and read bits 31:16 as zero. Control at 0x10 stores bit 1 (mode: 0 edge, 1 level) and bit 2 (enable), and reads every other bit as zero.
- R4: In edge mode with enable set, a 0-to-1 transition on a channel whose high select bit is set sets that channel's status bit.
- R5: In edge mode with enable set, a 1-to-0 transition on a channel whose low select bit is set sets that channel's status bit.
- R6: Inputs 16 to 31, and channels with both select bits clear, never set status or raise the interrupt.
- R7: In level mode with enable set, when every selected channel is at its selected level, the status bits of all selected channels are set. When only some of them are at their levels, nothing is set.
- R8: After a level-mode firing, no further firing occurs until the combined condition has been false for at least one cycle. Once the condition is re-established, the block fires again.
- R9: In level mode with no channel selected, the block never fires.
- R10: Status bits accumulate across events. A read at 0x0C returns the accumulated bits in 15:0 and clears them, except for any bit set in that same cycle.
- R11: The interrupt line is high exactly when status is non-zero and enable is set, with a one-cycle lag. Clearing enable lowers the line but keeps the status. While enable is clear, no new events are recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Asynchronous digital inputs |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
Edge mode is tried with single rising edges and single falling edges, each against the opposite select bit. This shows whether the direction selection is honoured. Toggling the upper inputs and unselected low channels shows whether those inputs are kept out of detection. Level mode is tried three ways: with a mixed high/low selection reached one channel at a time, which separates "all met" from "some met"; with the condition held across several status reads, which exposes a missing re-arm; and with an empty selection, which catches a vacuous "all of none" firing. Disabling the block in the middle of activity separates masking of the output from loss of status.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int BUS_W = 32;
  localparam logic [2:0] WORD_RAW  = 3'd0;
  localparam logic [2:0] WORD_HI   = 3'd1;
  localparam logic [2:0] WORD_LO   = 3'd2;
  localparam logic [2:0] WORD_STAT = 3'd3;
  localparam logic [2:0] WORD_CTRL = 3'd4;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_EN_BIT   = 2;
  typedef enum logic {MODE_EDGE = 1'b0, MODE_LEVEL = 1'b1} comb_mode_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= pipe[STAGES-1];
  end

  assign cur = pipe[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  comb_mode_t   mode,
  input  logic [N-1:0] sel_hi,
  input  logic [N-1:0] sel_lo,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  output logic [N-1:0] hit
);
  logic [N-1:0] edge_hit;
  logic [N-1:0] lvl_ok;
  logic [N-1:0] sel;
  logic         all_met;
  logic         armed;
  logic         fire;

  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      assign edge_hit[i] = (sel_hi[i] & cur[i] & ~prev[i]) |
                           (sel_lo[i] & ~cur[i] & prev[i]);
      assign lvl_ok[i]   = (sel_hi[i] & cur[i]) | (sel_lo[i] & ~cur[i]);
    end
  endgenerate

  assign sel     = sel_hi | sel_lo;
  assign all_met = (|sel) && (&(lvl_ok | ~sel));
  assign fire    = en && (mode == MODE_LEVEL) && all_met && armed;

  // re-arm only once the combined condition has dropped
  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b1;
    else if (!all_met) armed <= 1'b1;
    else if (fire)     armed <= 1'b0;
  end

  always_comb begin
    hit = '0;
    if (en) begin
      if (mode == MODE_EDGE) hit = edge_hit;
      else if (fire)         hit = sel;
    end
  end

  assert_level_one_shot_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LEVEL && hit != '0) |=> !(mode == MODE_LEVEL && hit != '0));

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !en |-> hit == '0);

  assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_EDGE) |-> (hit & ~(cur ^ prev)) == '0);
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int N_IN        = 32,
  parameter int N_IRQ       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  din,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_o
);
  localparam int PAD_IN  = BUS_W - N_IN;
  localparam int PAD_IRQ = BUS_W - N_IRQ;

  logic [N_IN-1:0]  in_cur, in_prev;
  logic [N_IRQ-1:0] sel_hi, sel_lo, status, hit;
  logic             ctrl_en;
  comb_mode_t       ctrl_mode;
  logic [2:0]       word;
  logic             stat_rd;

  assign word    = bus_addr[4:2];
  assign stat_rd = bus_rd && (word == WORD_STAT);

  cos_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(din), .cur(in_cur), .prev(in_prev)
  );

  cos_detect #(.N(N_IRQ)) u_detect (
    .clk(clk), .rst(rst), .en(ctrl_en), .mode(ctrl_mode),
    .sel_hi(sel_hi), .sel_lo(sel_lo),
    .cur(in_cur[N_IRQ-1:0]), .prev(in_prev[N_IRQ-1:0]), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hi    <= '0;
      sel_lo    <= '0;
      ctrl_en   <= 1'b0;
      ctrl_mode <= MODE_EDGE;
    end else if (bus_wr) begin
      case (word)
        WORD_HI:   sel_hi <= bus_wdata[N_IRQ-1:0];
        WORD_LO:   sel_lo <= bus_wdata[N_IRQ-1:0];
        WORD_CTRL: begin
          ctrl_en   <= bus_wdata[CTRL_EN_BIT];
          ctrl_mode <= comb_mode_t'(bus_wdata[CTRL_MODE_BIT]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (stat_rd ? '0 : status) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|status) & ctrl_en;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (word)
        WORD_RAW:  bus_rdata <= {{PAD_IN{1'b0}}, in_cur};
        WORD_HI:   bus_rdata <= {{PAD_IRQ{1'b0}}, sel_hi};
        WORD_LO:   bus_rdata <= {{PAD_IRQ{1'b0}}, sel_lo};
        WORD_STAT: bus_rdata <= {{PAD_IRQ{1'b0}}, status};
        WORD_CTRL: begin
          bus_rdata <= '0;
          bus_rdata[CTRL_EN_BIT]   <= ctrl_en;
          bus_rdata[CTRL_MODE_BIT] <= ctrl_mode;
        end
        default:   bus_rdata <= '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata, in_prev};

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_en));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && hit == '0) |=> status == '0);

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> (status & $past(status)) == $past(status));
endmodule

// File: tb/cos_irq_ctrl_bench.sv
module cos_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  cos_irq_ctrl u_cos_irq_ctrl (
    .clk(clk), .rst(rst), .din(din), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic quiesce();
    logic [31:0] d;
    wr(5'h10, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h0);
    settle();
    rd(5'h0C, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(irq_o == 1'b0, "R1 irq", {31'b0, irq_o}, 32'h0);
    rd(5'h0C, d); check(d == 0, "R1 status", d, 0);
    rd(5'h04, d); check(d == 0, "R1 high select", d, 0);
    rd(5'h08, d); check(d == 0, "R1 low select", d, 0);
    rd(5'h10, d); check(d == 0, "R1 control", d, 0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    din = 32'hA5C3_0F81; settle();
    rd(5'h00, d); check(d == 32'hA5C3_0F81, "R2 raw", d, 32'hA5C3_0F81);
    din = 32'h0; settle();
    rd(5'h00, d); check(d == 0, "R2 raw zero", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_1234); rd(5'h04, d); check(d == 32'h1234, "R3 high", d, 32'h1234);
    wr(5'h08, 32'hABCD_8001); rd(5'h08, d); check(d == 32'h8001, "R3 low", d, 32'h8001);
    wr(5'h10, 32'hFFFF_FFF9); rd(5'h10, d); check(d == 32'h0, "R3 ctrl other bits", d, 0);
    wr(5'h10, 32'h0000_0006); rd(5'h10, d); check(d == 32'h6, "R3 ctrl", d, 32'h6);
    quiesce();
  endtask

  task automatic t_or_rise();
    logic [31:0] d;
    wr(5'h04, 32'h0000_0010); wr(5'h10, 32'h4);
    din[4] = 1'b1; settle();
    rd(5'h0C, d); check(d == 32'h10, "R4 rising", d, 32'h10);
    din[4] = 1'b0; settle();
    rd(5'h0C, d); check(d == 0, "R4 falling not selected", d, 0);
    quiesce();
  endtask

  task automatic t_or_fall();
    logic [31:0] d;
    din[9] = 1'b1; settle();
    wr(5'h08, 32'h0000_0200); wr(5'h10, 32'h4);
    din[9] = 1'b0; settle();
    rd(5'h0C, d); check(d == 32'h200, "R5 falling", d, 32'h200);
    din[9] = 1'b1; settle();
    rd(5'h0C, d); check(d == 0, "R5 rising not selected", d, 0);
    din[9] = 1'b0; quiesce();
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_0001); wr(5'h08, 32'hFFFF_0001); wr(5'h10, 32'h4);
    din[31:16] = 16'hFFFF; din[5] = 1'b1; settle();
    din[31:16] = 16'h0;    din[5] = 1'b0; settle();
    check(irq_o == 1'b0, "R6 irq", {31'b0, irq_o}, 0);
    rd(5'h0C, d); check(d == 0, "R6 status", d, 0);
    quiesce();
  endtask

  task automatic t_and_level();
    logic [31:0] d;
    din[2] = 1'b1;
    wr(5'h04, 32'h1); wr(5'h08, 32'h4); wr(5'h10, 32'h6);
    din[0] = 1'b1; settle();
    rd(5'h0C, d); check(d == 0, "R7 partial", d, 0);
    din[2] = 1'b0; settle();
    rd(5'h0C, d); check(d == 32'h5, "R7 all met", d, 32'h5);
    din[0] = 1'b0; quiesce();
  endtask

  task automatic t_and_rearm();
    logic [31:0] d;
    wr(5'h04, 32'h3); wr(5'h10, 32'h6);
    din[1:0] = 2'b11; settle();
    rd(5'h0C, d); check(d == 32'h3, "R8 first fire", d, 32'h3);
    settle();
    rd(5'h0C, d); check(d == 0, "R8 held no refire", d, 0);
    din[0] = 1'b0; settle();
    rd(5'h0C, d); check(d == 0, "R8 released", d, 0);
    din[0] = 1'b1; settle();
    rd(5'h0C, d); check(d == 32'h3, "R8 refire", d, 32'h3);
    din[1:0] = 2'b00; quiesce();
  endtask

  task automatic t_and_empty();
    logic [31:0] d;
    wr(5'h10, 32'h6);
    din[15:0] = 16'hFFFF; settle();
    din[15:0] = 16'h0;    settle();
    check(irq_o == 1'b0, "R9 irq", {31'b0, irq_o}, 0);
    rd(5'h0C, d); check(d == 0, "R9 status", d, 0);
    quiesce();
  endtask

  task automatic t_accum();
    logic [31:0] d;
    wr(5'h04, 32'h0000_8002); wr(5'h10, 32'h4);
    din[1] = 1'b1; settle();
    din[15] = 1'b1; settle();
    rd(5'h0C, d); check(d == 32'h8002, "R10 accumulated", d, 32'h8002);
    rd(5'h0C, d); check(d == 0, "R10 cleared by read", d, 0);
    din[1] = 1'b0; din[15] = 1'b0; quiesce();
  endtask

  task automatic t_irq_gate();
    logic [31:0] d;
    wr(5'h04, 32'h8); wr(5'h10, 32'h4);
    din[3] = 1'b1; settle();
    check(irq_o == 1'b1, "R11 irq raised", {31'b0, irq_o}, 1);
    wr(5'h10, 32'h0); settle();
    check(irq_o == 1'b0, "R11 irq masked", {31'b0, irq_o}, 0);
    din[3] = 1'b0; settle(); din[3] = 1'b1; settle();
    rd(5'h0C, d); check(d == 32'h8, "R11 status kept", d, 32'h8);
    din[3] = 1'b0; settle(); din[3] = 1'b1; settle();
    wr(5'h10, 32'h4); settle();
    check(irq_o == 1'b0, "R11 nothing recorded while off", {31'b0, irq_o}, 0);
    rd(5'h0C, d); check(d == 0, "R11 status while off", d, 0);
    din[3] = 1'b0; quiesce();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_raw();
    t_regs();
    t_or_rise();
    t_or_fall();
    t_ignore();
    t_and_level();
    t_and_rearm();
    t_and_empty();
    t_accum();
    t_irq_gate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule